// File: doc/BRIEF.md
# Prioritized Shared-Register Update Controller

This block keeps two wrapping counters, `x` and `y`, that three requesters share. The fill requester adds one to `x`. The move requester takes one unit out of `x` and puts it into `y` as a single transfer. The drain requester removes one from `y`. Each requester raises its own request bit. On every clock edge the block picks the set of requesters that may run together and applies all of their updates on that edge.

The move requester touches both counters, so it conflicts with the other two. The fill and drain requesters use different counters and may run in the same cycle whenever the move requester does not run. A static parameter selects how the drain and move requesters rank against each other. The fill requester always ranks lowest. The block also reports, on registered outputs, which requesters ran on the most recent edge.

Top module: `shared_cnt_ctrl`

## Requirements
- R1: After reset, `x_o`, `y_o` and `fire_o` are all zero.
- R2: When the fill requester (request bit 0) runs, `x_o` increases by one on that edge.
- R3: When the move requester (request bit 1) runs, `x_o` decreases by one and `y_o` increases by one on the same edge. Neither change happens without the other.
- R4: When the drain requester (request bit 2) runs, `y_o` decreases by one on that edge.
- R5: A requester never runs in a cycle where its request bit is low. With no requests, the counters hold and `fire_o` is zero.
- R6: No counter takes updates from two requesters on one edge: `fire_o` never has bits 0 and 1 set together, or bits 1 and 2 set together.
- R7: When request bits 0 and 2 are high and bit 1 is low, requesters 0 and 2 both run on the same edge (`fire_o` = 3'b101).
- R8: With the default ranking (`PRIO_TAKE_FIRST`), a high request bit 2 always runs. Requester 1 runs only if bit 1 is high and bit 2 is low.
- R9: With the alternate ranking (`PRIO_MOVE_FIRST`), a high request bit 1 always runs. Requester 2 runs only if bit 2 is high and bit 1 is low.
- R10: Under either ranking, requester 0 runs exactly when its bit is high and requester 1 does not run.
- R11: Both counters are `WIDTH` bits wide and wrap modulo 2^`WIDTH` in both directions.
- R12: `fire_o` is registered. Bit i is set for one cycle after the edge on which requester i ran, and it clears on the next edge if requester i does not run again.
- R13: The sum `x_o + y_o` (mod 2^`WIDTH`) changes only through requesters 0 and 2: it gains one for a fill and loses one for a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update takes effect on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request bits: bit 0 fill, bit 1 move, bit 2 drain |
| x_o | output | WIDTH | Current value of counter x |
| y_o | output | WIDTH | Current value of counter y |
| fire_o | output | 3 | Requesters that ran on the most recent edge, bit order as `req_i` |

## Verification
Every result is due one clock edge after its request is presented. The request is sampled on a rising edge, and the counters and `fire_o` change on that same edge, with no extra pipeline stage. The bench changes `req_i` only on falling edges and updates its arithmetic model at the same moment. It then compares all three outputs on the next falling edge, which falls half a period after the edge that produced them. This lets every check see exactly one edge's worth of effect, and the same rule applies to both ranking variants, which run side by side on identical requests.

// File: rtl/shcnt_pkg.sv
package shcnt_pkg;

    // Number of requesters sharing the counters.
    localparam int NPROC = 3;

    // Requester positions in the request and fire vectors.
    localparam int P_FILL = 0;   // adds one to x
    localparam int P_MOVE = 1;   // x minus one, y plus one
    localparam int P_TAKE = 2;   // subtracts one from y

    // Number of shared counters.
    localparam int NREG = 2;

    // Ranking between the two requesters that touch y.
    typedef enum logic {
        PRIO_TAKE_FIRST = 1'b0,  // drain > move > fill
        PRIO_MOVE_FIRST = 1'b1   // move > drain > fill
    } prio_e;

endpackage

// File: rtl/shcnt_grant.sv
module shcnt_grant
    import shcnt_pkg::*;
#(
    parameter prio_e PRIO = PRIO_TAKE_FIRST
) (
    input  logic [NPROC-1:0] req_i,
    output logic [NPROC-1:0] grant_o
);

    logic take_win;
    logic move_win;

    // The parameter picks which of the two y users wins a tie.
    generate
        if (PRIO == PRIO_TAKE_FIRST) begin : g_take_first
            always_comb begin
                take_win = req_i[P_TAKE];
                move_win = req_i[P_MOVE] & ~req_i[P_TAKE];
            end
        end else begin : g_move_first
            always_comb begin
                move_win = req_i[P_MOVE];
                take_win = req_i[P_TAKE] & ~req_i[P_MOVE];
            end
        end
    endgenerate

    // Fill shares only x with move, so it yields to move alone.
    always_comb begin
        grant_o          = '0;
        grant_o[P_TAKE]  = take_win;
        grant_o[P_MOVE]  = move_win;
        grant_o[P_FILL]  = req_i[P_FILL] & ~move_win;
    end

endmodule

// File: rtl/shcnt_step.sv
module shcnt_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             up_i,
    input  logic             dn_i,
    output logic [WIDTH-1:0] nxt_o
);

    // Wrapping step of one shared counter; both strobes cancel out.
    always_comb begin
        unique case ({up_i, dn_i})
            2'b10:   nxt_o = cur_i + 1'b1;
            2'b01:   nxt_o = cur_i - 1'b1;
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/shared_cnt_ctrl.sv
module shared_cnt_ctrl
    import shcnt_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter prio_e PRIO  = PRIO_TAKE_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] req_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic [NPROC-1:0] fire_o
);

    localparam int REG_X = 0;
    localparam int REG_Y = 1;

    typedef struct packed {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
        logic [NPROC-1:0] fire;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NPROC-1:0] grant;
    logic [WIDTH-1:0] cur  [NREG];
    logic [WIDTH-1:0] nxt  [NREG];
    logic [NREG-1:0]  up;
    logic [NREG-1:0]  dn;

    shcnt_grant #(
        .PRIO (PRIO)
    ) u_grant (
        .req_i   (req_i),
        .grant_o (grant)
    );

    // Which requester raises or lowers which counter.
    always_comb begin
        cur[REG_X] = state_q.x;
        cur[REG_Y] = state_q.y;
        up[REG_X]  = grant[P_FILL];
        dn[REG_X]  = grant[P_MOVE];
        up[REG_Y]  = grant[P_MOVE];
        dn[REG_Y]  = grant[P_TAKE];
    end

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            shcnt_step #(
                .WIDTH (WIDTH)
            ) u_step (
                .cur_i (cur[r]),
                .up_i  (up[r]),
                .dn_i  (dn[r]),
                .nxt_o (nxt[r])
            );
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        state_d.x    = nxt[REG_X];
        state_d.y    = nxt[REG_Y];
        state_d.fire = grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign x_o    = state_q.x;
    assign y_o    = state_q.y;
    assign fire_o = state_q.fire;

endmodule

// File: rtl/shcnt_checker.sv
module shcnt_checker
    import shcnt_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter prio_e PRIO  = PRIO_TAKE_FIRST
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPROC-1:0] req_i,
    input logic [WIDTH-1:0] x_o,
    input logic [WIDTH-1:0] y_o,
    input logic [NPROC-1:0] fire_o
);

    logic [WIDTH-1:0] total;
    assign total = WIDTH'(x_o + y_o);

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o[P_FILL] |-> x_o == WIDTH'($past(x_o) + 1'b1)); // R2

    AST_MOVE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o[P_MOVE] |-> (x_o == WIDTH'($past(x_o) - 1'b1)) && (y_o == WIDTH'($past(y_o) + 1'b1))); // R3

    AST_TAKE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o[P_TAKE] |-> y_o == WIDTH'($past(y_o) - 1'b1)); // R4

    AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o & ~$past(req_i)) == '0); // R5

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_o[P_FILL] && fire_o[P_MOVE]) && !(fire_o[P_MOVE] && fire_o[P_TAKE])); // R6

    AST_OUTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) == 3'b101) |-> fire_o == 3'b101); // R7

    AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i[P_FILL]) |-> (fire_o[P_FILL] != fire_o[P_MOVE])); // R10

    AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        total == WIDTH'($past(total) + fire_o[P_FILL] - fire_o[P_TAKE])); // R13

    generate
        if (PRIO == PRIO_TAKE_FIRST) begin : g_take_first
            AST_TAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(req_i[P_TAKE]) |-> fire_o[P_TAKE] && !fire_o[P_MOVE]); // R8
        end else begin : g_move_first
            AST_MOVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(req_i[P_MOVE]) |-> fire_o[P_MOVE] && !fire_o[P_TAKE]); // R9
        end
    endgenerate

endmodule

bind shared_cnt_ctrl shcnt_checker #(
    .WIDTH (WIDTH),
    .PRIO  (PRIO)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .x_o    (x_o),
    .y_o    (y_o),
    .fire_o (fire_o)
);

// File: tb/shared_cnt_ctrl_test.sv
`timescale 1ns/1ps
module shared_cnt_ctrl_test;
    import shcnt_pkg::*;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   req = 3'b000;
    logic [W-1:0] xa, ya, xb, yb;
    logic [2:0]   fa, fb;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [W-1:0] ex_a = '0, ey_a = '0, ex_b = '0, ey_b = '0;
    logic [2:0]   ef_a = '0, ef_b = '0;

    always #4 clk = ~clk;   // 8 ns period

    shared_cnt_ctrl #(.WIDTH(W), .PRIO(PRIO_TAKE_FIRST)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .x_o(xa), .y_o(ya), .fire_o(fa));

    shared_cnt_ctrl #(.WIDTH(W), .PRIO(PRIO_MOVE_FIRST)) uut_alt (
        .clk(clk), .rst_n(rst_n), .req_i(req), .x_o(xb), .y_o(yb), .fire_o(fb));

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Fires predicted from the ranking rules of R8, R9 and R10.
    function automatic logic [2:0] predict(input logic [2:0] c, input bit move_first);
        logic [2:0] f;
        if (!move_first) begin
            f[2] = c[2];
            f[1] = c[1] & ~c[2];
        end else begin
            f[1] = c[1];
            f[2] = c[2] & ~c[1];
        end
        f[0] = c[0] & ~f[1];
        return f;
    endfunction

    task automatic apply(input logic [2:0] c);
        logic [W-1:0] sa, sb;
        req  = c;
        ef_a = predict(c, 1'b0);
        ef_b = predict(c, 1'b1);
        sa   = W'(ex_a + ey_a);
        sb   = W'(ex_b + ey_b);
        ex_a = W'(ex_a + ef_a[0] - ef_a[1]);
        ey_a = W'(ey_a + ef_a[1] - ef_a[2]);
        ex_b = W'(ex_b + ef_b[0] - ef_b[1]);
        ey_b = W'(ey_b + ef_b[1] - ef_b[2]);
        @(negedge clk);
        check("R2 x default", xa, ex_a);
        check("R2 x alt",     xb, ex_b);
        check("R4 y default", ya, ey_a);
        check("R4 y alt",     yb, ey_b);
        check("R8 fire default", fa, ef_a);
        check("R9 fire alt",     fb, ef_b);
        check("R6 one writer", int'((fa[0] & fa[1]) | (fa[1] & fa[2]) | (fb[0] & fb[1]) | (fb[1] & fb[2])), 0);
        check("R13 sum default", W'(xa + ya), W'(sa + ef_a[0] - ef_a[2]));
        check("R13 sum alt",     W'(xb + yb), W'(sb + ef_b[0] - ef_b[2]));
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 x", xa, 0); check("R1 y", ya, 0); check("R1 fire", fa, 0);
        check("R1 x alt", xb, 0); check("R1 y alt", yb, 0); check("R1 fire alt", fb, 0);
        rst_n = 1'b1;
        @(negedge clk);

        apply(3'b100);                       // drain from zero wraps down
        check("R11 y wraps to max", ya, 15);
        apply(3'b010);                       // move: x wraps down, y wraps up
        check("R3 x moved", xa, 15); check("R3 y moved", ya, 0);
        check("R3 x moved alt", xb, 15); check("R3 y moved alt", yb, 0);
        apply(3'b101);
        check("R7 outer pair default", fa, 3'b101);
        check("R7 outer pair alt", fb, 3'b101);
        apply(3'b000);
        check("R5 no fire", fa | fb, 0);
        check("R12 fire cleared", fa, 0);
        check("R5 x held", xa, ex_a);
        apply(3'b110);
        check("R8 drain wins", fa, 3'b100);
        check("R9 move wins", fb, 3'b010);
        apply(3'b011);
        check("R10 fill blocked default", fa, 3'b010);
        check("R10 fill blocked alt", fb, 3'b010);
        apply(3'b001);
        check("R10 fill runs", fa, 3'b001);
        apply(3'b001);
        check("R12 fire held while requested", fa, 3'b001);

        // Every request pattern after every other, repeated.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                apply(3'(a));
                apply(3'(b));
            end
        end
        // Scrambled patterns.
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            apply(lfsr[2:0]);
        end
        // Long fill run wraps x upward.
        for (int i = 0; i < 20; i++) apply(3'b001);
        check("R11 x after fill run", xa, ex_a);

        done = 1;
        summary();
    end

endmodule